// File: doc/BRIEF.md
# Expansion Pin Direction and Output Register Bank

This block keeps the drive state of several banks of bidirectional expansion pins. Each bank has one register that says which pins are driven (output-enable) and one that holds the level driven on those pins. Software updates these registers through a plain write port made of a strobe, an address and a 32-bit data word. Every write is a per-bit masked update: the upper half of the word selects which bits change, and the lower half gives their new values. Selected pins can therefore be flipped without first reading the register back.

A small debug-select register, also written with a mask, can hand any bank to an internal debug source. While a bank is handed over, both its output-enable and its output level come from the debug inputs. The bank's own registers keep their contents and take effect again as soon as the bank is released. The outputs are flat output-enable and output-level vectors, one 16-bit slice per bank, intended to feed tristate pads.

Top module: `pin_bank_regs`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every output-enable bit, every output-level bit and every debug-select bit is 0, so all pins are inputs.
- R2: A write to an output-enable register loads data bit i into register bit i for each i in 0..15 where data bit 16+i is 1. Bits whose mask bit is 0 keep their value. The result is visible on `pin_oe` one clock after the write.
- R3: A write to an output-level register applies the same masked update (mask in bits 31:16, value in bits 15:0) and is visible on `pin_out` one clock after the write.
- R4: Output-enable registers sit at addresses 5, 6, 7 and 8 for banks 0 to 3. Output-level registers sit at addresses 9, 10, 11 and 12 for banks 0 to 3. Bank b drives slice [16*b+15:16*b] of each output vector.
- R5: A write whose bits 31:16 are all zero changes no register.
- R6: A write to any address other than 5 to 12 and 14 changes no register.
- R7: The debug-select register at address 14 holds one bit per bank, with bit b selecting bank b. It is updated with the mask in bits 19:16 and the values in bits 3:0.
- R8: While a bank's debug-select bit is 1, its slices of `pin_oe` and `pin_out` equal the matching slices of `dbg_oe` and `dbg_out` in the same cycle. Clearing the bit restores the bank's register values.
- R9: While a bank's debug-select bit is 0, the debug inputs have no effect on that bank's outputs.
- R10: With `wr_en` low, the values on `wr_addr` and `wr_data` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Mask in 31:16, value in 15:0 |
| dbg_oe | input | 64 | Debug output-enable, 16 bits per bank |
| dbg_out | input | 64 | Debug output level, 16 bits per bank |
| pin_oe | output | 64 | Output-enable to pads, 1 means driven |
| pin_out | output | 64 | Output level to pads |

## Verification
The bench uses the default parameters: four banks of 16 pins and a 5-bit address. With a 5-bit address, every one of the 32 addresses can be swept with a set of mask/value patterns, so all in-range and out-of-range targets are covered, along with the all-zero mask. Four banks put every debug-select combination within reach. This exercises both handover and release against registers holding non-trivial contents, while the debug inputs sweep values that differ from the registers.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_OE   = 2'd1,
    TGT_LVL  = 2'd2,
    TGT_DBG  = 2'd3
  } reg_target_e;
endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 5,
  parameter int OE_BASE   = 5,
  parameter int LVL_BASE  = 9,
  parameter int DBG_ADDR  = 14
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  output logic [NUM_BANKS-1:0] oe_we,
  output logic [NUM_BANKS-1:0] lvl_we,
  output logic                 dbg_we,
  output pin_bank_pkg::reg_target_e target
);
  import pin_bank_pkg::*;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign oe_we[b]  = wr_en && (wr_addr == ADDR_W'(OE_BASE + b));
    assign lvl_we[b] = wr_en && (wr_addr == ADDR_W'(LVL_BASE + b));
  end

  assign dbg_we = wr_en && (wr_addr == ADDR_W'(DBG_ADDR));

  always_comb begin
    if (|oe_we)       target = TGT_OE;
    else if (|lvl_we) target = TGT_LVL;
    else if (dbg_we)  target = TGT_DBG;
    else              target = TGT_NONE;
  end
endmodule

// File: rtl/pin_bank_mask_reg.sv
module pin_bank_mask_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] value,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] next_q;

  always_comb begin
    next_q = (q & ~mask) | (value & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= next_q;
  end
endmodule

// File: rtl/pin_bank_out_mux.sv
module pin_bank_out_mux #(
  parameter int PIN_W = 16
) (
  input  logic             sel_dbg,
  input  logic [PIN_W-1:0] reg_oe,
  input  logic [PIN_W-1:0] reg_lvl,
  input  logic [PIN_W-1:0] dbg_oe,
  input  logic [PIN_W-1:0] dbg_lvl,
  output logic [PIN_W-1:0] pad_oe,
  output logic [PIN_W-1:0] pad_lvl
);
  always_comb begin
    if (sel_dbg) begin
      pad_oe  = dbg_oe;
      pad_lvl = dbg_lvl;
    end else begin
      pad_oe  = reg_oe;
      pad_lvl = reg_lvl;
    end
  end
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs #(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 16,
  parameter int ADDR_W    = 5,
  parameter int OE_BASE   = 5,
  parameter int LVL_BASE  = 9,
  parameter int DBG_ADDR  = 14,
  localparam int DATA_W   = 2 * PIN_W,
  localparam int BUS_W    = NUM_BANKS * PIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BUS_W-1:0]  dbg_oe,
  input  logic [BUS_W-1:0]  dbg_out,
  output logic [BUS_W-1:0]  pin_oe,
  output logic [BUS_W-1:0]  pin_out
);
  logic [NUM_BANKS-1:0] oe_we;
  logic [NUM_BANKS-1:0] lvl_we;
  logic                 dbg_we;
  logic [BUS_W-1:0]     oe_q;
  logic [BUS_W-1:0]     val_q;
  logic [NUM_BANKS-1:0] dbg_q;
  pin_bank_pkg::reg_target_e wr_target;

  logic [PIN_W-1:0] wr_mask;
  logic [PIN_W-1:0] wr_value;
  assign wr_mask  = wr_data[DATA_W-1:PIN_W];
  assign wr_value = wr_data[PIN_W-1:0];

  pin_bank_decode #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .OE_BASE(OE_BASE),
    .LVL_BASE(LVL_BASE), .DBG_ADDR(DBG_ADDR)
  ) decode_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .oe_we(oe_we),
    .lvl_we(lvl_we), .dbg_we(dbg_we), .target(wr_target)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pin_bank_mask_reg #(.WIDTH(PIN_W)) oe_reg_i (
      .clk(clk), .rst_n(rst_n),
      .we(oe_we[b] && (wr_target == pin_bank_pkg::TGT_OE)),
      .mask(wr_mask), .value(wr_value), .q(oe_q[b*PIN_W +: PIN_W])
    );
    pin_bank_mask_reg #(.WIDTH(PIN_W)) lvl_reg_i (
      .clk(clk), .rst_n(rst_n),
      .we(lvl_we[b] && (wr_target == pin_bank_pkg::TGT_LVL)),
      .mask(wr_mask), .value(wr_value), .q(val_q[b*PIN_W +: PIN_W])
    );
    pin_bank_out_mux #(.PIN_W(PIN_W)) mux_i (
      .sel_dbg(dbg_q[b]),
      .reg_oe(oe_q[b*PIN_W +: PIN_W]), .reg_lvl(val_q[b*PIN_W +: PIN_W]),
      .dbg_oe(dbg_oe[b*PIN_W +: PIN_W]), .dbg_lvl(dbg_out[b*PIN_W +: PIN_W]),
      .pad_oe(pin_oe[b*PIN_W +: PIN_W]), .pad_lvl(pin_out[b*PIN_W +: PIN_W])
    );
  end

  pin_bank_mask_reg #(.WIDTH(NUM_BANKS)) dbg_reg_i (
    .clk(clk), .rst_n(rst_n),
    .we(dbg_we && (wr_target == pin_bank_pkg::TGT_DBG)),
    .mask(wr_mask[NUM_BANKS-1:0]), .value(wr_value[NUM_BANKS-1:0]),
    .q(dbg_q)
  );
endmodule

// File: rtl/pin_bank_regs_chk.sv
module pin_bank_regs_chk #(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 16,
  parameter int ADDR_W    = 5,
  parameter int OE_BASE   = 5,
  parameter int LVL_BASE  = 9,
  parameter int DBG_ADDR  = 14,
  localparam int DATA_W   = 2 * PIN_W,
  localparam int BUS_W    = NUM_BANKS * PIN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [BUS_W-1:0]  dbg_oe,
  input logic [BUS_W-1:0]  dbg_out,
  input logic [BUS_W-1:0]  pin_oe,
  input logic [BUS_W-1:0]  pin_out,
  input logic [BUS_W-1:0]  oe_q,
  input logic [BUS_W-1:0]  val_q,
  input logic [NUM_BANKS-1:0] dbg_q
);
  logic in_range;
  assign in_range = (int'(wr_addr) >= OE_BASE && int'(wr_addr) < OE_BASE + NUM_BANKS) ||
                    (int'(wr_addr) >= LVL_BASE && int'(wr_addr) < LVL_BASE + NUM_BANKS) ||
                    (int'(wr_addr) == DBG_ADDR);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (oe_q == '0 && val_q == '0 && dbg_q == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(oe_q) && $stable(val_q) && $stable(dbg_q))); // R10

  AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DATA_W-1:PIN_W] == '0) |=>
      ($stable(oe_q) && $stable(val_q) && $stable(dbg_q))); // R5

  AST_OUT_OF_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> ($stable(oe_q) && $stable(val_q) && $stable(dbg_q))); // R6

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_OE_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(OE_BASE + b)) |=>
        ((((oe_q[b*PIN_W +: PIN_W] ^ $past(oe_q[b*PIN_W +: PIN_W])) & ~$past(wr_data[DATA_W-1:PIN_W])) |
          ((oe_q[b*PIN_W +: PIN_W] ^ $past(wr_data[PIN_W-1:0])) & $past(wr_data[DATA_W-1:PIN_W]))) == '0)); // R2

    AST_LVL_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(LVL_BASE + b)) |=>
        ((((val_q[b*PIN_W +: PIN_W] ^ $past(val_q[b*PIN_W +: PIN_W])) & ~$past(wr_data[DATA_W-1:PIN_W])) |
          ((val_q[b*PIN_W +: PIN_W] ^ $past(wr_data[PIN_W-1:0])) & $past(wr_data[DATA_W-1:PIN_W]))) == '0)); // R3

    AST_DBG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_q[b] |-> (pin_oe[b*PIN_W +: PIN_W] == dbg_oe[b*PIN_W +: PIN_W] &&
                    pin_out[b*PIN_W +: PIN_W] == dbg_out[b*PIN_W +: PIN_W])); // R8

    AST_REG_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_q[b] |-> (pin_oe[b*PIN_W +: PIN_W] == oe_q[b*PIN_W +: PIN_W] &&
                     pin_out[b*PIN_W +: PIN_W] == val_q[b*PIN_W +: PIN_W])); // R9
  end
endmodule

bind pin_bank_regs pin_bank_regs_chk #(
  .NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W), .ADDR_W(ADDR_W),
  .OE_BASE(OE_BASE), .LVL_BASE(LVL_BASE), .DBG_ADDR(DBG_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .dbg_oe(dbg_oe), .dbg_out(dbg_out), .pin_oe(pin_oe), .pin_out(pin_out),
  .oe_q(oe_q), .val_q(val_q), .dbg_q(dbg_q)
);

// File: tb/pin_bank_regs_tb_top.sv
module pin_bank_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int PW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] dbg_oe = '0;
  logic [63:0] dbg_out = '0;
  logic [63:0] pin_oe;
  logic [63:0] pin_out;

  int checks = 0;
  int failures = 0;

  logic [15:0] m_oe [NB];
  logic [15:0] m_val [NB];
  logic [NB-1:0] m_dbg;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_bank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_oe(dbg_oe), .dbg_out(dbg_out), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_oe[b] = '0;
      m_val[b] = '0;
    end
    m_dbg = '0;
  endtask

  task automatic model_write(input int addr, input logic [31:0] d);
    logic [15:0] mk;
    logic [15:0] v;
    mk = d[31:16];
    v  = d[15:0];
    if (addr >= 5 && addr <= 8)       m_oe[addr-5]  = (m_oe[addr-5] & ~mk) | (v & mk);
    else if (addr >= 9 && addr <= 12) m_val[addr-9] = (m_val[addr-9] & ~mk) | (v & mk);
    else if (addr == 14)              m_dbg = (m_dbg & ~mk[NB-1:0]) | (v[NB-1:0] & mk[NB-1:0]);
  endtask

  task automatic check_pins(input string tag);
    logic [63:0] e_oe;
    logic [63:0] e_out;
    for (int b = 0; b < NB; b++) begin
      e_oe[b*PW +: PW]  = m_dbg[b] ? dbg_oe[b*PW +: PW]  : m_oe[b];
      e_out[b*PW +: PW] = m_dbg[b] ? dbg_out[b*PW +: PW] : m_val[b];
    end
    checks++;
    if (pin_oe !== e_oe || pin_out !== e_out) begin
      failures++;
      $display("FAIL %s oe=%h out=%h expected oe=%h out=%h", tag, pin_oe, pin_out, e_oe, e_out);
    end
  endtask

  task automatic do_write(input int addr, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 5'(addr);
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(addr, d);
  endtask

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0: return 32'hFFFF_A5C3;
      1: return 32'h00FF_1234;
      2: return 32'hF0F0_FFFF;
      3: return 32'h0000_BEEF;
      4: return 32'hFFFF_0000;
      default: return 32'h0F0F_5A5A;
    endcase
  endfunction

  function automatic string tag_of(input int addr, input logic [31:0] d);
    if (d[31:16] == 16'h0)           return "R5 zero-mask";
    if (addr >= 5 && addr <= 8)      return "R2 R4 oe-write";
    if (addr >= 9 && addr <= 12)     return "R3 R4 level-write";
    if (addr == 14)                  return "R7 R8 debug-select";
    return "R6 out-of-range";
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    dbg_oe  = 64'h0123_4567_89AB_CDEF;
    dbg_out = 64'hFEDC_BA98_7654_3210;
    repeat (3) @(negedge clk);
    check_pins("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 after reset");

    // Sweep every address with every pattern, twice over.
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 6; k++) begin
        for (int a = 0; a < 32; a++) begin
          logic [31:0] d;
          d = pattern((k + pass * 3) % 6) ^ {16'h0, 16'(a * 16'h0101)};
          do_write(a, d);
          check_pins(tag_of(a, d));
        end
      end
    end

    // R10: strobe low, address and data toggle
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      wr_addr = 5'(a);
      wr_data = 32'hFFFF_0000 ^ 32'(a * 32'h0007_0013);
      @(negedge clk);
      check_pins("R10 strobe low");
    end

    // R9: no bank selected, debug inputs swept
    do_write(14, 32'h000F_0000);
    for (int v = 0; v < 16; v++) begin
      dbg_oe  = {4{16'(v * 16'h1111)}};
      dbg_out = ~dbg_oe;
      #1;
      check_pins("R9 debug ignored");
    end

    // R7 R8: every debug-select combination, inputs changing while selected
    dbg_oe  = 64'hAAAA_5555_CCCC_3333;
    dbg_out = 64'h0F0F_F0F0_00FF_FF00;
    for (int s = 0; s < 16; s++) begin
      do_write(14, {28'h000F_000, 4'(s)});
      check_pins("R7 select combination");
      dbg_oe = ~dbg_oe;
      #1;
      check_pins("R8 debug follows");
    end
    for (int b = 0; b < NB; b++) begin
      do_write(14, {16'(1 << b), 16'h0});
      check_pins("R8 release restores");
    end

    // R1: reset mid-run clears everything
    do_write(14, 32'h000F_000F);
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    check_pins("R1 reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 after second reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule